// File: doc/BRIEF.md
# Fan Speed Pulse Width Modulator

This block turns two register values into one fan drive waveform. An 8-bit fan register supplies a 6-bit duty code, a rate select bit and a force-high bit. Two control bits, a source select and a doubling bit, join the rate select bit to choose one of eight output frequencies. Four frequencies are in the kilohertz range and four in the hertz range. Every output period has 64 equal steps. The output is high for the first DCC steps, where DCC is the duty code.

The step rate is 64 times the chosen frequency. A phase accumulator that runs on the system clock produces it, so fractional rates such as 1.5 MHz or 2560 Hz average out exactly. A new duty code or rate takes effect only where one period ends and the next begins, so no shortened pulse reaches the fan. The two static states act at once. A set force bit drives the output high. A zero duty code with the force bit clear drives it low.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: While reset is held, and after it is released until the first period boundary, the output is low. Reset loads duty code 0 and rate index 0.
- R2: Fan register bit positions: bit 7 is the rate select, bits 6..1 are the duty code (DCC) and bit 0 is force-high. The control inputs are the source select and the doubling bit.
- R3: For DCC from 1 to 63, with the force bit clear, the output is high for exactly DCC of the 64 steps in each period and low for the rest. Each period starts high.
- R4: With DCC = 63 the output is low for exactly one step (1/64) of each period. It is never high for the whole period.
- R5: With force-high at 1, the output is high from the second clock edge onward, whatever the duty code, rate select and control bits hold.
- R6: With force-high at 0 and DCC = 0, the output is low from the second clock edge onward, even partway through a high pulse.
- R7: With the doubling bit at 0, the pair (source, select) gives these output frequencies: (0,0) 15.625 kHz, (0,1) 23.4375 kHz, (1,0) 40 Hz and (1,1) 60 Hz.
- R8: With the doubling bit at 1, each of the four pairs gives twice its R7 frequency: 31.25 kHz, 46.875 kHz, 80 Hz and 120 Hz.
- R9: Step ticks come from a phase accumulator of modulus SYS_CLK_HZ that restarts at each period boundary. A period of 64 steps lasts exactly SYS_CLK_HZ / f system clocks when f divides SYS_CLK_HZ. The first step after a boundary lasts ceil(SYS_CLK_HZ / (64·f)) clocks.
- R10: A change of duty code or rate selection made partway through a period leaves that period unchanged. It takes effect from the next period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at SYS_CLK_HZ |
| rst_n | input | 1 | Synchronous reset, active low |
| fan_reg_i | input | 8 | Fan register: bit 7 rate select, bits 6..1 duty code, bit 0 force-high |
| ctl_mult_i | input | 1 | Frequency doubling bit |
| ctl_src_i | input | 1 | Source select: 0 kHz range, 1 Hz range |
| pwm_o | output | 1 | Fan drive output |

## Verification
The bench sweeps every duty code and counts the high clocks over whole periods. A comparison that is off by one would show up as 64/64 at code 63 or as one step too many at every code. The rate tests measure the period length for the four fast settings and the first step width for the four slow ones. A swapped select and source bit, a missing doubling bit or an accumulator that drifts would change those counts. A duty code or rate written in the middle of a pulse must leave that pulse alone. A design that loads at once would produce a runt pulse that the bench catches. The force checks look at the second clock edge after the write, so a static state that waited for the period boundary would fail.

// File: rtl/fan_pwm_pkg.sv
// Shared types and rate table for the fan pulse width modulator.
// Assumes a 6-bit duty code, so every period has 64 steps.
package fan_pwm_pkg;

    localparam int unsigned DUTY_W      = 6;
    localparam int unsigned STEPS       = 1 << DUTY_W;
    localparam int unsigned MAX_TICK_HZ = 3_000_000;

    // Rate index formed from the three selection bits
    typedef struct packed {
        logic mult;
        logic src;
        logic sel;
    } fan_rate_t;

    // Step tick frequency in Hz (64 x output frequency) for a rate index
    function automatic int unsigned tick_rate_hz(fan_rate_t r);
        int unsigned base;
        case ({r.src, r.sel})
            2'b00:   base = 1_000_000;
            2'b01:   base = 1_500_000;
            2'b10:   base = 2_560;
            default: base = 3_840;
        endcase
        return r.mult ? (base << 1) : base;
    endfunction

endpackage

// File: rtl/fan_rate_gen.sv
// Step tick generator: a phase accumulator of modulus SYS_CLK_HZ adds the
// selected tick rate on every clock and emits a one-cycle tick on each wrap.
// Assumes SYS_CLK_HZ >= MAX_TICK_HZ so that at most one tick falls per clock.
// restart_i clears the phase so every period starts in the same phase.
module fan_rate_gen
    import fan_pwm_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 48_000_000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  fan_rate_t rate_i,
    input  logic      restart_i,
    output logic      tick_o
);
    localparam int unsigned      ACC_W   = $clog2(SYS_CLK_HZ) + 1;
    localparam logic [ACC_W-1:0] MODULUS = ACC_W'(SYS_CLK_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] sum;

    // Next phase and wrap detection
    always_comb begin
        inc    = ACC_W'(tick_rate_hz(rate_i));
        sum    = acc_q + inc;
        tick_o = (sum >= MODULUS);
    end

    // Phase register: restart at a period boundary, otherwise wrap modulo
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (restart_i) acc_q <= '0;
        else if (tick_o)    acc_q <= sum - MODULUS;
        else                acc_q <= sum;
    end

    // R9
    acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < MODULUS);

endmodule

// File: rtl/fan_period_ctr.sv
// Step position counter with the period-boundary load of duty code and rate.
// Assumes tick_i is a single-cycle pulse. wrap_o marks the last step's tick.
module fan_period_ctr
    import fan_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [DUTY_W-1:0] dcc_i,
    input  fan_rate_t         rate_i,
    output logic [DUTY_W-1:0] pos_o,
    output logic [DUTY_W-1:0] dcc_o,
    output fan_rate_t         rate_o,
    output logic              wrap_o
);
    logic [DUTY_W-1:0] pos_q;
    logic [DUTY_W-1:0] dcc_q;
    fan_rate_t         rate_q;

    // End of period: tick while on the last step
    always_comb wrap_o = tick_i && (pos_q == {DUTY_W{1'b1}});

    // Advance the position; load new settings only at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            dcc_q  <= '0;
            rate_q <= '0;
        end else begin
            if (tick_i) pos_q <= pos_q + 1'b1;
            if (wrap_o) begin
                dcc_q  <= dcc_i;
                rate_q <= rate_i;
            end
        end
    end

    assign pos_o  = pos_q;
    assign dcc_o  = dcc_q;
    assign rate_o = rate_q;

    // R3
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(pos_q));

    // R10
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_o |=> ($stable(dcc_q) && $stable(rate_q)));

endmodule

// File: rtl/fan_pwm_out.sv
// Output stage: compares the step position against the loaded duty code and
// applies the static states, which act on the live register bits at once.
// Assumes pos_i and dcc_q_i come from the period counter.
module fan_pwm_out
    import fan_pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              force_hi_i,
    input  logic [DUTY_W-1:0] dcc_live_i,
    input  logic [DUTY_W-1:0] pos_i,
    input  logic [DUTY_W-1:0] dcc_q_i,
    output logic              pwm_o
);
    logic pwm_d;
    logic pwm_q;

    // Output level: force-high wins, a zero code holds low, else compare
    always_comb begin
        if (force_hi_i)              pwm_d = 1'b1;
        else if (dcc_live_i == '0)   pwm_d = 1'b0;
        else                         pwm_d = (pos_i < dcc_q_i);
    end

    // Output register, low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q;

    // R5
    force_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_hi_i |=> pwm_q);

    // R6
    force_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_hi_i && dcc_live_i == '0) |=> !pwm_q);

endmodule

// File: rtl/fan_pwm_ctrl.sv
// Fan speed PWM top: splits the fan register into its fields, builds the rate
// index, and links the tick generator, period counter and output stage.
// Assumes register inputs are synchronous to clk and SYS_CLK_HZ >= 3 MHz.
module fan_pwm_ctrl
    import fan_pwm_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 48_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] fan_reg_i,
    input  logic       ctl_mult_i,
    input  logic       ctl_src_i,
    output logic       pwm_o
);
    fan_rate_t         rate_req;
    fan_rate_t         rate_act;
    logic [DUTY_W-1:0] dcc_live;
    logic [DUTY_W-1:0] dcc_act;
    logic [DUTY_W-1:0] pos;
    logic              force_hi;
    logic              tick;
    logic              wrap;

    // Register field split
    always_comb begin
        rate_req.mult = ctl_mult_i;
        rate_req.src  = ctl_src_i;
        rate_req.sel  = fan_reg_i[7];
        dcc_live      = fan_reg_i[6:1];
        force_hi      = fan_reg_i[0];
    end

    fan_rate_gen #(.SYS_CLK_HZ(SYS_CLK_HZ)) u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_i    (rate_act),
        .restart_i (wrap),
        .tick_o    (tick)
    );

    fan_period_ctr u_period (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .dcc_i  (dcc_live),
        .rate_i (rate_req),
        .pos_o  (pos),
        .dcc_o  (dcc_act),
        .rate_o (rate_act),
        .wrap_o (wrap)
    );

    fan_pwm_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .force_hi_i (force_hi),
        .dcc_live_i (dcc_live),
        .pos_i      (pos),
        .dcc_q_i    (dcc_act),
        .pwm_o      (pwm_o)
    );

endmodule

// File: tb/sim_fan_pwm_ctrl.sv
`timescale 1ns/1ps
// Directed bench for fan_pwm_ctrl. SYS_CLK_HZ is set to 3 MHz so that every
// rate fits in the run; the 200 MHz clock is only the simulation time base.
module sim_fan_pwm_ctrl;
    localparam int SYS = 3_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] fan_reg = 8'h00;
    logic       ctl_mult = 1'b0;
    logic       ctl_src = 1'b0;
    logic       pwm_o;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    fan_pwm_ctrl #(.SYS_CLK_HZ(SYS)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fan_reg_i  (fan_reg),
        .ctl_mult_i (ctl_mult),
        .ctl_src_i  (ctl_src),
        .pwm_o      (pwm_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Independent step tick rate from R7/R8: 64 x output frequency
    function automatic int tick_hz(input bit mult, input bit src, input bit sel);
        int b;
        if (!src) b = sel ? 1_500_000 : 1_000_000;
        else      b = sel ? 3_840 : 2_560;
        return mult ? 2 * b : b;
    endfunction

    task automatic set_regs(input bit sel, input int dcc, input bit frc,
                            input bit mult, input bit src);
        fan_reg  = {sel, 6'(dcc), frc};
        ctl_mult = mult;
        ctl_src  = src;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Wait for the next rising edge of the output, sampled at negedges
    task automatic wait_rise(input string req, output bit found);
        logic prev;
        prev  = pwm_o;
        found = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!prev && pwm_o) begin
                found = 1;
                break;
            end
            prev = pwm_o;
        end
        if (!found) check(0, req, "no rising edge", 0, 1);
    endtask

    // Called at the negedge of a rise: count high and total clocks to next rise
    task automatic measure(output int hi, output int tot);
        logic prev;
        hi = 1; tot = 1; prev = 1'b1;
        for (int i = 0; i < 100000; i++) begin
            @(negedge clk);
            if (!prev && pwm_o) break;
            tot++;
            if (pwm_o) hi++;
            prev = pwm_o;
        end
    endtask

    task automatic t_reset();
        int highs;
        set_regs(1, 63, 0, 1, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(pwm_o == 1'b0, "R1", "output during reset", pwm_o, 0);
        rst_n = 1'b1;
        highs = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (pwm_o) highs++;
        end
        check(highs == 0, "R1", "high clocks before first boundary", highs, 0);
    endtask

    // R3, R4, R2: every duty code at 15.625 kHz (3 clocks per step)
    task automatic t_duty_sweep();
        int hi, tot;
        bit f;
        do_reset();
        for (int d = 1; d < 64; d++) begin
            set_regs(0, d, 0, 0, 0);
            wait_rise("R3", f);
            wait_rise("R3", f);
            measure(hi, tot);
            check(hi == 3 * d, "R3", $sformatf("high clocks dcc=%0d", d), hi, 3 * d);
            check(tot == 192, "R3", $sformatf("period dcc=%0d", d), tot, 192);
            if (d == 63)
                check(tot - hi == 3, "R4", "low clocks at dcc 63", tot - hi, 3);
        end
    endtask

    // R7, R8, R2: fast rates, whole period length and half duty
    task automatic t_rates_fast();
        int hi, tot, exp_tot;
        bit f;
        for (int k = 0; k < 4; k++) begin
            bit mult = k[1];
            bit sel  = k[0];
            set_regs(sel, 32, 0, mult, 0);
            wait_rise("R7", f);
            wait_rise("R7", f);
            measure(hi, tot);
            exp_tot = SYS / (tick_hz(mult, 0, sel) / 64);
            check(tot == exp_tot, mult ? "R8" : "R7",
                  $sformatf("period mult=%0d sel=%0d", mult, sel), tot, exp_tot);
            check(hi == exp_tot / 2, "R9",
                  $sformatf("half duty mult=%0d sel=%0d", mult, sel), hi, exp_tot / 2);
        end
    endtask

    // R7, R8, R9: slow rates, first step width after the boundary
    task automatic t_rates_slow();
        int w, th, exp_w;
        bit f;
        for (int k = 0; k < 4; k++) begin
            bit mult = k[1];
            bit sel  = k[0];
            do_reset();
            set_regs(sel, 1, 0, mult, 1);
            wait_rise("R9", f);
            w = 1;
            for (int i = 0; i < 5000; i++) begin
                @(negedge clk);
                if (!pwm_o) break;
                w++;
            end
            th    = tick_hz(mult, 1, sel);
            exp_w = (SYS + th - 1) / th;
            check(w == exp_w, mult ? "R8" : "R7",
                  $sformatf("step width mult=%0d sel=%0d (R9)", mult, sel), w, exp_w);
        end
    endtask

    // R10: mid-period writes wait for the boundary
    task automatic t_boundary();
        int hi, tot;
        bit f;
        do_reset();
        set_regs(0, 10, 0, 0, 0);
        wait_rise("R10", f);
        wait_rise("R10", f);
        set_regs(1, 50, 0, 0, 0);
        measure(hi, tot);
        check(hi == 30, "R10", "high clocks of current period", hi, 30);
        check(tot == 192, "R10", "length of current period", tot, 192);
        measure(hi, tot);
        check(hi == 100, "R10", "high clocks of next period", hi, 100);
        check(tot == 128, "R10", "length of next period", tot, 128);
    endtask

    // R5, R6: static states act at once
    task automatic t_force();
        int cnt;
        bit f;
        do_reset();
        set_regs(0, 1, 0, 0, 0);
        wait_rise("R5", f);
        repeat (10) @(negedge clk);
        check(pwm_o == 1'b0, "R5", "low before force", pwm_o, 0);
        set_regs(0, 1, 1, 0, 0);
        @(negedge clk);
        check(pwm_o == 1'b1, "R5", "high one edge after force", pwm_o, 1);
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!pwm_o) cnt++;
        end
        check(cnt == 0, "R5", "low clocks while forced", cnt, 0);
        fan_reg = 8'h01;
        ctl_src = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!pwm_o) cnt++;
        end
        check(cnt == 0, "R5", "low clocks forced with dcc 0", cnt, 0);
        fan_reg = 8'h00;
        @(negedge clk);
        check(pwm_o == 1'b0, "R6", "low one edge after dcc 0", pwm_o, 0);
        cnt = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pwm_o) cnt++;
        end
        check(cnt == 0, "R6", "high clocks with dcc 0", cnt, 0);
        do_reset();
        set_regs(0, 63, 0, 0, 0);
        wait_rise("R6", f);
        @(negedge clk);
        check(pwm_o == 1'b1, "R6", "high inside pulse", pwm_o, 1);
        fan_reg = 8'h00;
        @(negedge clk);
        check(pwm_o == 1'b0, "R6", "cut mid pulse", pwm_o, 0);
    endtask

    initial begin
        t_reset();
        t_duty_sweep();
        t_rates_fast();
        t_rates_slow();
        t_boundary();
        t_force();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: 190,000 clocks at 5 ns
    initial begin
        #950_000;
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule